// File: doc/BRIEF.md
# Signed 2x2 Max-Pooling Stage

This block halves the spatial resolution of a multi-channel feature map. It reads the input map from a synchronous memory port whose read latency is a parameter. For each output element it fetches the four members of one non-overlapping 2x2 window, keeps the largest value as a signed number, and writes that value once to the output memory. Both maps are stored channel first, then row, then column, each packed without gaps.

A controller starts the stage with a one-cycle `start` pulse. The stage then holds `busy` and owns both memories until it emits a one-cycle `done` pulse. Exactly one read is outstanding at any time. The stage waits the configured latency before it uses each returned word, so the read sequence on the port is fixed and can be checked address by address. Strides other than two, padding and other window sizes are not supported.

Top module: `maxpool2x2_stage`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `rd_en` and `wr_en` are all low.
- R2: A `start` pulse while idle raises `busy` on the next cycle. `busy` stays high until the run ends. `done` is high for exactly one cycle, and `busy` is low during that cycle.
- R3: For output (c,y,x), the four reads are issued in this order: (2y,2x), (2y,2x+1), (2y+1,2x), (2y+1,2x+1). Input element (c,row,col) is at address (c*IN_H+row)*IN_W+col.
- R4: At most one read is in flight. `rd_data` is used exactly RD_LAT cycles after its `rd_en`, and consecutive reads are RD_LAT+1 cycles apart.
- R5: Each output is the two's-complement maximum of its four inputs. The first returned value seeds the maximum, so all-negative windows are exact. Only a strictly greater value replaces the maximum.
- R6: Outputs are written channel-major, then by row, then by column, to address (c*IN_H/2+y)*IN_W/2+x. Every output address is written exactly once per run.
- R7: `rd_addr` stays below CHANNELS*IN_H*IN_W and `wr_addr` stays below a quarter of that.
- R8: A `start` pulse while `busy` is high is ignored. The run finishes with the same reads, writes and timing.
- R9: `rd_en` and `wr_en` are asserted only while `busy` is high.
- R10: `done` goes high exactly OUT_WORDS*(4*(RD_LAT+1)+1) clock edges after the edge that samples `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle run request |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Input memory read request |
| rd_addr | output | clog2(CHANNELS*IN_H*IN_W) | Input memory read address |
| rd_data | input | DATA_W | Read data, valid RD_LAT cycles after `rd_en` |
| wr_en | output | 1 | Output memory write strobe |
| wr_addr | output | clog2(CHANNELS*IN_H*IN_W/4) | Output memory write address |
| wr_data | output | DATA_W | Window maximum, two's complement |

## Verification
Two cases are hard to reach from the ports. One is a window whose maximum sits in each of the four tap positions in turn. The other is a window whose values are all negative or lie at the extremes of the signed range. Generated image patterns place the winner at a rotating tap, fill every window with negatives, and mix -128, 0 and 127. A memory model delays data by exactly RD_LAT cycles, so a wrong latency count or a reordered tap would return a neighbour's value. A second `start` pulse is injected mid-run to show that it changes nothing.

// File: rtl/pool_pkg.sv
// Package for the pooling stage: controller states and a width helper.
// Assumes only that every user imports it before it declares ports.
package pool_pkg;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_ISSUE,
        PS_WAIT,
        PS_WRITE,
        PS_FIN
    } pool_state_e;

    // Bits needed to index n items; never less than one.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pool_lat_pipe.sv
// Tracks one read request through the memory latency. ret_valid is high
// in the cycle in which rd_data holds the word for a request made LAT
// cycles earlier. Assumes LAT >= 1.
module pool_lat_pipe #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic ret_valid
);
    generate
        if (LAT == 1) begin : g_one
            logic v_q;
            // Single-stage delay of the request flag.
            always_ff @(posedge clk) begin
                if (!rst_n) v_q <= 1'b0;
                else        v_q <= req;
            end
            assign ret_valid = v_q;
        end else begin : g_many
            logic [LAT-1:0] sr_q;
            // Shift register of the request flag, one bit per latency cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) sr_q <= '0;
                else        sr_q <= {sr_q[LAT-2:0], req};
            end
            assign ret_valid = sr_q[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/pool_addr_gen.sv
// Walks output coordinates (channel, row, column) and the tap inside the
// current window. From these it forms the input read address and the output
// write address. Assumes even IN_H and IN_W.
module pool_addr_gen import pool_pkg::*; #(
    parameter int CHANNELS = 2,
    parameter int IN_H     = 4,
    parameter int IN_W     = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   clear,
    input  logic                                   step_tap,
    input  logic                                   step_out,
    output logic [idx_w(CHANNELS*IN_H*IN_W)-1:0]   rd_addr,
    output logic [idx_w(CHANNELS*IN_H*IN_W/4)-1:0] wr_addr,
    output logic                                   first_tap,
    output logic                                   last_tap,
    output logic                                   last_out
);
    localparam int OUT_H = IN_H / 2;
    localparam int OUT_W = IN_W / 2;
    localparam int RA_W  = idx_w(CHANNELS*IN_H*IN_W);
    localparam int WA_W  = idx_w(CHANNELS*OUT_H*OUT_W);
    localparam int CW    = idx_w(CHANNELS);
    localparam int YW    = idx_w(OUT_H);
    localparam int XW    = idx_w(OUT_W);

    logic [CW-1:0] c_q;
    logic [YW-1:0] y_q;
    logic [XW-1:0] x_q;
    logic [1:0]    tap_q;

    logic x_end, y_end, c_end;
    assign x_end = (x_q == XW'(OUT_W - 1));
    assign y_end = (y_q == YW'(OUT_H - 1));
    assign c_end = (c_q == CW'(CHANNELS - 1));

    // Tap and coordinate counters; the column moves fastest, the channel slowest.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            c_q   <= '0;
            y_q   <= '0;
            x_q   <= '0;
            tap_q <= '0;
        end else if (step_tap) begin
            tap_q <= tap_q + 2'd1;
        end else if (step_out) begin
            tap_q <= '0;
            if (!x_end) begin
                x_q <= x_q + 1'b1;
            end else begin
                x_q <= '0;
                if (!y_end) begin
                    y_q <= y_q + 1'b1;
                end else begin
                    y_q <= '0;
                    c_q <= c_q + 1'b1;
                end
            end
        end
    end

    // Tap bit 1 selects the lower row, tap bit 0 the right column.
    assign rd_addr = RA_W'((32'(c_q) * IN_H + 2 * 32'(y_q) + 32'(tap_q[1])) * IN_W
                           + 2 * 32'(x_q) + 32'(tap_q[0]));
    assign wr_addr = WA_W'((32'(c_q) * OUT_H + 32'(y_q)) * OUT_W + 32'(x_q));

    assign first_tap = (tap_q == 2'd0);
    assign last_tap  = (tap_q == 2'd3);
    assign last_out  = x_end && y_end && c_end;
endmodule

// File: rtl/pool_max_unit.sv
// Running signed maximum of one window. The first sample loads the value
// unconditionally; a later sample replaces it only when strictly greater.
module pool_max_unit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              first,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] max_q
);
    logic greater;
    assign greater = $signed(din) > $signed(max_q);

    // Seed on the first tap, then keep the larger in two's complement.
    always_ff @(posedge clk) begin
        if (!rst_n)                         max_q <= '0;
        else if (load && (first || greater)) max_q <= din;
    end
endmodule

// File: rtl/maxpool2x2_stage.sv
// 2x2 stride-2 signed max-pooling stage with a start/busy/done handshake.
// Issues one read at a time, waits RD_LAT cycles for the data, and writes
// each window maximum once. Assumes even IN_H and IN_W, and RD_LAT >= 1.
module maxpool2x2_stage import pool_pkg::*; #(
    parameter int DATA_W   = 8,
    parameter int CHANNELS = 2,
    parameter int IN_H     = 4,
    parameter int IN_W     = 4,
    parameter int RD_LAT   = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    output logic                                   busy,
    output logic                                   done,
    output logic                                   rd_en,
    output logic [idx_w(CHANNELS*IN_H*IN_W)-1:0]   rd_addr,
    input  logic [DATA_W-1:0]                      rd_data,
    output logic                                   wr_en,
    output logic [idx_w(CHANNELS*IN_H*IN_W/4)-1:0] wr_addr,
    output logic [DATA_W-1:0]                      wr_data
);
    pool_state_e state_q;
    logic ret_valid, first_tap, last_tap, last_out;
    logic gen_clear, step_tap, step_out, take;

    assign gen_clear = (state_q == PS_IDLE) && start;
    assign take      = (state_q == PS_WAIT) && ret_valid;
    assign step_tap  = take && !last_tap;
    assign step_out  = (state_q == PS_WRITE) && !last_out;

    // Controller: issue, wait for the data, and after four taps write the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_IDLE;
        end else begin
            case (state_q)
                PS_IDLE:  if (start) state_q <= PS_ISSUE;
                PS_ISSUE: state_q <= PS_WAIT;
                PS_WAIT:  if (ret_valid) state_q <= last_tap ? PS_WRITE : PS_ISSUE;
                PS_WRITE: state_q <= last_out ? PS_FIN : PS_ISSUE;
                PS_FIN:   state_q <= PS_IDLE;
                default:  state_q <= PS_IDLE;
            endcase
        end
    end

    pool_addr_gen #(.CHANNELS(CHANNELS), .IN_H(IN_H), .IN_W(IN_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .clear(gen_clear),
        .step_tap(step_tap), .step_out(step_out),
        .rd_addr(rd_addr), .wr_addr(wr_addr),
        .first_tap(first_tap), .last_tap(last_tap), .last_out(last_out)
    );

    pool_lat_pipe #(.LAT(RD_LAT)) u_lat (
        .clk(clk), .rst_n(rst_n), .req(rd_en), .ret_valid(ret_valid)
    );

    pool_max_unit #(.DATA_W(DATA_W)) u_max (
        .clk(clk), .rst_n(rst_n), .load(take), .first(first_tap),
        .din(rd_data), .max_q(wr_data)
    );

    assign rd_en = (state_q == PS_ISSUE);
    assign wr_en = (state_q == PS_WRITE);
    assign busy  = (state_q == PS_ISSUE) || (state_q == PS_WAIT) || (state_q == PS_WRITE);
    assign done  = (state_q == PS_FIN);
endmodule

// File: rtl/maxpool2x2_checker.sv
// Protocol checker for maxpool2x2_stage, attached through bind.
// Observes the top-level ports only and keeps its own small counters.
module maxpool2x2_checker import pool_pkg::*; #(
    parameter int DATA_W   = 8,
    parameter int CHANNELS = 2,
    parameter int IN_H     = 4,
    parameter int IN_W     = 4,
    parameter int RD_LAT   = 2
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   start,
    input logic                                   busy,
    input logic                                   done,
    input logic                                   rd_en,
    input logic [idx_w(CHANNELS*IN_H*IN_W)-1:0]   rd_addr,
    input logic [DATA_W-1:0]                      rd_data,
    input logic                                   wr_en,
    input logic [idx_w(CHANNELS*IN_H*IN_W/4)-1:0] wr_addr,
    input logic [DATA_W-1:0]                      wr_data
);
    localparam int IN_WORDS  = CHANNELS * IN_H * IN_W;
    localparam int OUT_WORDS = IN_WORDS / 4;
    localparam int WA_W      = idx_w(OUT_WORDS);
    localparam int GAP_W     = idx_w(RD_LAT + 3);

    logic [GAP_W-1:0] since_rd_q;
    logic [WA_W-1:0]  next_wr_q;

    // Cycles since the last read, saturating above the required spacing.
    always_ff @(posedge clk) begin
        if (!rst_n)                         since_rd_q <= GAP_W'(RD_LAT + 2);
        else if (rd_en)                     since_rd_q <= GAP_W'(1);
        else if (since_rd_q < GAP_W'(RD_LAT + 2)) since_rd_q <= since_rd_q + 1'b1;
    end

    // Next output address expected in the write order.
    always_ff @(posedge clk) begin
        if (!rst_n || done) next_wr_q <= '0;
        else if (wr_en)     next_wr_q <= next_wr_q + 1'b1;
    end

    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy);
    a_r4_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (since_rd_q >= GAP_W'(RD_LAT + 1)));
    a_r6_write_order: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_addr == next_wr_q));
    a_r7_read_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (32'(rd_addr) < IN_WORDS));
    a_r7_write_range: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_addr) < OUT_WORDS));
    a_r9_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> busy);
    a_r9_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> busy);
endmodule

bind maxpool2x2_stage maxpool2x2_checker #(
    .DATA_W(DATA_W), .CHANNELS(CHANNELS), .IN_H(IN_H), .IN_W(IN_W), .RD_LAT(RD_LAT)
) u_checker (.*);

// File: tb/test_maxpool2x2_stage.sv
module test_maxpool2x2_stage;
    localparam int DATA_W    = 8;
    localparam int CHANNELS  = 2;
    localparam int IN_H      = 4;
    localparam int IN_W      = 4;
    localparam int RD_LAT    = 2;
    localparam int OUT_H     = IN_H / 2;
    localparam int OUT_W     = IN_W / 2;
    localparam int IN_WORDS  = CHANNELS * IN_H * IN_W;
    localparam int OUT_WORDS = IN_WORDS / 4;
    localparam int RA_W      = $clog2(IN_WORDS);
    localparam int WA_W      = $clog2(OUT_WORDS);
    localparam int RUN_EDGES = OUT_WORDS * (4 * (RD_LAT + 1) + 1);

    // Stimulus table: image pattern and the expected maximum of output 0.
    localparam int NVEC = 5;
    localparam int VEC_MODE[NVEC] = '{0, 1, 2, 3, 4};
    localparam int VEC_OUT0[NVEC] = '{-1, 68, -5, 127, 50};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic busy, done, rd_en, wr_en;
    logic [RA_W-1:0]   rd_addr;
    logic [WA_W-1:0]   wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;

    logic [DATA_W-1:0] mem_in  [IN_WORDS];
    logic [DATA_W-1:0] mem_out [OUT_WORDS];
    logic              seen    [OUT_WORDS];
    logic [DATA_W-1:0] dpipe   [RD_LAT];

    int checks = 0;
    int fails = 0;
    int rd_count = 0;
    int wr_count = 0;
    int stray = 0;

    always #4 clk = ~clk;

    maxpool2x2_stage #(
        .DATA_W(DATA_W), .CHANNELS(CHANNELS), .IN_H(IN_H), .IN_W(IN_W), .RD_LAT(RD_LAT)
    ) i_maxpool2x2_stage (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    // Memory model: the word for an address sampled at one edge is valid RD_LAT edges later.
    always @(posedge clk) begin
        dpipe[0] <= mem_in[rd_addr];
        for (int i = 1; i < RD_LAT; i++) dpipe[i] <= dpipe[i-1];
    end
    assign rd_data = dpipe[RD_LAT-1];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rd_expect(input int n);
        int o = n / 4;
        int t = n % 4;
        int c = o / (OUT_H * OUT_W);
        int y = (o / OUT_W) % OUT_H;
        int x = o % OUT_W;
        return (c * IN_H + 2 * y + t / 2) * IN_W + 2 * x + t % 2;
    endfunction

    function automatic int max_expect(input int o);
        int m = $signed(mem_in[rd_expect(o * 4)]);
        for (int t = 1; t < 4; t++) begin
            int v = $signed(mem_in[rd_expect(o * 4 + t)]);
            if (v > m) m = v;
        end
        return m;
    endfunction

    function automatic int pix(input int mode, input int idx);
        int c   = idx / (IN_H * IN_W);
        int row = (idx / IN_W) % IN_H;
        int col = idx % IN_W;
        int tap = (row % 2) * 2 + col % 2;
        int wi  = (c * OUT_H + row / 2) * OUT_W + col / 2;
        case (mode)
            0:       return -1 - ((idx * 7) % 100);
            1:       return ((idx * 37 + 11) % 256) - 128;
            2:       return -5;
            3:       return ((idx * 5) % 3 == 0) ? -128 : (((idx * 5) % 3 == 1) ? 127 : 0);
            default: return (tap == wi % 4) ? 50 : -20 - tap;
        endcase
    endfunction

    // Port monitor: read order, write address, value and once-only writes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (start && !busy && !done) begin
                rd_count = 0;
                wr_count = 0;
                for (int i = 0; i < OUT_WORDS; i++) seen[i] = 1'b0;
            end
            if ((rd_en || wr_en) && !busy) stray++;
            if (rd_en) begin
                chk(int'(rd_addr) == rd_expect(rd_count), "R3 read order", int'(rd_addr), rd_expect(rd_count));
                chk(int'(rd_addr) < IN_WORDS, "R7 read range", int'(rd_addr), IN_WORDS - 1);
                rd_count++;
            end
            if (wr_en) begin
                chk(int'(wr_addr) == wr_count, "R6 write order", int'(wr_addr), wr_count);
                chk($signed(wr_data) == max_expect(wr_count), "R5 window max", $signed(wr_data), max_expect(wr_count));
                chk(!seen[wr_addr], "R6 single write", 1, 0);
                seen[wr_addr] = 1'b1;
                mem_out[wr_addr] = wr_data;
                wr_count++;
            end
        end
    end

    task automatic run(input int mode, input int exp0, input bit poke);
        int n = 0;
        for (int i = 0; i < IN_WORDS; i++) mem_in[i] = DATA_W'(pix(mode, i));
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        chk(busy === 1'b1, "R2 busy after start", int'(busy), 1);
        while (!done && n < RUN_EDGES + 20) begin
            if (poke && n == 10) start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
            n++;
        end
        chk(n == RUN_EDGES, "R10 run length", n, RUN_EDGES);
        chk(!busy, "R2 busy low with done", int'(busy), 0);
        @(posedge clk); #1;
        chk(!done, "R2 done single cycle", int'(done), 1'b0);
        chk(wr_count == OUT_WORDS, poke ? "R8 writes after extra start" : "R6 write count", wr_count, OUT_WORDS);
        chk(rd_count == IN_WORDS, poke ? "R8 reads after extra start" : "R4 read count", rd_count, IN_WORDS);
        chk($signed(mem_out[0]) == exp0, "R5 table output 0", $signed(mem_out[0]), exp0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports.
        chk(!busy && !done && !rd_en && !wr_en, "R1 reset state",
            int'({busy, done, rd_en, wr_en}), 0);
        for (int v = 0; v < NVEC; v++) run(VEC_MODE[v], VEC_OUT0[v], 1'b0);
        // R8: extra start in the middle of a run.
        run(1, 68, 1'b1);
        // R9: nothing moves on the memory ports while idle.
        repeat (12) @(posedge clk);
        #1;
        chk(stray == 0, "R9 access outside busy", stray, 0);
        chk(!busy && !rd_en && !wr_en, "R9 idle after run", int'({busy, rd_en, wr_en}), 0);
        // R1: reset in the middle of a run returns to idle.
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        repeat (7) @(posedge clk);
        #1 rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        chk(!busy && !done && !rd_en && !wr_en, "R1 reset mid-run",
            int'({busy, done, rd_en, wr_en}), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule